// File: doc/BRIEF.md
# Periodic Interrupt and Pulse Output Generator

This block drives an open-drain, active-low periodic output pin and keeps a flag that records each period event. A 4-bit control word picks one of four periods from a set of timebase taps, picks between a fixed-width pulse and a level that holds until the flag is cleared, and can mask the pin. A second write target holds the event flag. Software can clear this flag but cannot set it.

The fast tap is a one-cycle strobe at 128 Hz. An internal divider derives the 1/64 s event from that strobe. The 1 s, 1 min and 1 h events come in as one-cycle carry strobes from the calendar. The bus decode and the calendar counters sit outside the block. The pin is modelled as a pull-down enable: 1 means the pin is driven low, and 0 means it is released.

Top module: `periodic_out_gen`

## Requirements
- R1: After reset the pin is released, the flag reads 0 and the control readback reads 0.
- R2: Control bits [3:2] select the event source: 00 = every second `tick_fast` strobe (the second strobe after reset is the first event), 01 = `carry_sec`, 10 = `carry_min`, 11 = `carry_hour`. Strobes on unselected taps do not set the flag.
- R3: A selected event sets the flag on the next clock edge. The flag stays set until it is cleared.
- R4: A write with `wr_to_flag`=1 and `wr_data[2]`=0 clears the flag. A write with `wr_data[2]`=1 leaves the flag unchanged.
- R5: When an event and a clear fall in the same cycle, the event wins and the flag stays 1.
- R6: In standard mode (control bit 1 = 0), each event drives the pin low from the next edge. The pin stays low until PULSE_TICKS further `tick_fast` strobes have been counted.
- R7: In interrupt mode (control bit 1 = 1), the pin is low exactly while the flag is 1 and the mask is 0. It is released on the same edge that clears the flag.
- R8: With the mask (control bit 0) set, the pin is released in both modes, while events still set the flag.
- R9: A write with `wr_to_flag`=0 loads `wr_data` into the control word. The control word reads back on `ctrl_rd`.
- R10: An event during an active standard pulse restarts the full pulse width. When it coincides with a strobe, the restart takes priority over the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | 128 Hz one-cycle strobe |
| carry_sec | input | 1 | Seconds carry strobe |
| carry_min | input | 1 | Minutes carry strobe |
| carry_hour | input | 1 | Hours carry strobe |
| wr_en | input | 1 | Write strobe |
| wr_to_flag | input | 1 | 0 = control word, 1 = flag register |
| wr_data | input | 4 | Write data |
| ctrl_rd | output | 4 | Control word readback |
| flag_rd | output | 1 | Event flag |
| pin_pull_low | output | 1 | 1 = drive the open-drain pin low |

## Verification
The bench builds the block with PULSE_TICKS = 2. With that width, a pulse in the 1/64 s setting is always restarted before it can end. This makes retriggering and the priority of a restart over a coinciding strobe observable. With the 1 s setting, the bench can still see the pulse end after two strobes. Random strobes and writes, run against a bench reference model, bring all four tap settings, masked and unmasked, and collisions of clears with events within reach.

// File: rtl/periodic_out_pkg.sv
package periodic_out_pkg;

  typedef enum logic [1:0] {
    PER_64HZ = 2'b00,
    PER_SEC  = 2'b01,
    PER_MIN  = 2'b10,
    PER_HOUR = 2'b11
  } per_sel_e;

  typedef struct packed {
    per_sel_e per;
    logic     irq_mode;
    logic     mask;
  } ctrl_word_t;

  localparam int FLAG_CLR_BIT = 2;

  function automatic logic pick_event(input per_sel_e sel, input logic ev64,
                                      input logic sec, input logic min,
                                      input logic hr);
    case (sel)
      PER_64HZ: return ev64;
      PER_SEC:  return sec;
      PER_MIN:  return min;
      default:  return hr;
    endcase
  endfunction

  function automatic logic is_flag_clear(input logic we, input logic to_flag,
                                         input logic [3:0] d);
    return we && to_flag && !d[FLAG_CLR_BIT];
  endfunction

endpackage

// File: rtl/pog_tap_select.sv
module pog_tap_select
  import periodic_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  per_sel_e sel,
  input  logic     tick_fast,
  input  logic     carry_sec,
  input  logic     carry_min,
  input  logic     carry_hour,
  output logic     evt
);
  logic div_q;
  logic ev64;

  always_ff @(posedge clk) begin
    if (!rst_n)         div_q <= 1'b0;
    else if (tick_fast) div_q <= ~div_q;
  end

  assign ev64 = tick_fast & div_q;
  assign evt  = pick_event(sel, ev64, carry_sec, carry_min, carry_hour);

  AST_EVT_NEEDS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (tick_fast | carry_sec | carry_min | carry_hour)); // R2
  AST_64_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ev64 && !$past(!rst_n)) |-> !$past(ev64)); // R2
endmodule

// File: rtl/pog_pulse_timer.sv
module pog_pulse_timer #(
  parameter int PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic busy
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(PULSE_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= LOAD_VAL;
    else if (step && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R6
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && !load) |=> busy); // R6
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load)); // R10
endmodule

// File: rtl/pog_flag_reg.sv
module pog_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R3
  AST_FLAG_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(evt)); // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag); // R4
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt) |=> flag); // R5
endmodule

// File: rtl/periodic_out_gen.sv
module periodic_out_gen
  import periodic_out_pkg::*;
#(
  parameter int PULSE_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_fast,
  input  logic       carry_sec,
  input  logic       carry_min,
  input  logic       carry_hour,
  input  logic       wr_en,
  input  logic       wr_to_flag,
  input  logic [3:0] wr_data,
  output logic [3:0] ctrl_rd,
  output logic       flag_rd,
  output logic       pin_pull_low
);
  ctrl_word_t ctrl_q;
  logic       evt;
  logic       clr_req;
  logic       pulse_busy;
  logic       flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    ctrl_q <= '0;
    else if (wr_en && !wr_to_flag) ctrl_q <= ctrl_word_t'(wr_data);
  end

  assign clr_req = is_flag_clear(wr_en, wr_to_flag, wr_data);

  pog_tap_select u_taps (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_q.per), .tick_fast(tick_fast),
    .carry_sec(carry_sec), .carry_min(carry_min), .carry_hour(carry_hour),
    .evt(evt)
  );

  pog_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load(evt), .step(tick_fast), .busy(pulse_busy)
  );

  pog_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_req), .flag(flag_q)
  );

  assign ctrl_rd      = ctrl_q;
  assign flag_rd      = flag_q;
  assign pin_pull_low = !ctrl_q.mask && (ctrl_q.irq_mode ? flag_q : pulse_busy);

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mask |-> !pin_pull_low); // R8
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.irq_mode && !ctrl_q.mask) |-> (pin_pull_low == flag_rd)); // R7
endmodule

// File: tb/tb_periodic_out_gen.sv
module tb_periodic_out_gen;
  localparam int CLK_NS = 10;
  localparam int PT = 2;

  logic clk = 0, rst_n = 0;
  logic tf = 0, cs = 0, cm = 0, ch = 0, we = 0, wa = 0;
  logic [3:0] wd = 0;
  logic [3:0] ctrl_rd;
  logic flag_rd, pin;
  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  periodic_out_gen #(.PULSE_TICKS(PT)) dut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tf), .carry_sec(cs), .carry_min(cm),
    .carry_hour(ch), .wr_en(we), .wr_to_flag(wa), .wr_data(wd),
    .ctrl_rd(ctrl_rd), .flag_rd(flag_rd), .pin_pull_low(pin));

  // reference model built from the requirements
  logic [3:0] m_ctrl; logic m_flag, m_half; int m_left;
  function automatic logic model_event(input logic [1:0] s, input logic half);
    if (s == 2'd0) return tf && half;
    if (s == 2'd1) return cs;
    if (s == 2'd2) return cm;
    return ch;
  endfunction
  function automatic logic model_pin();
    if (m_ctrl[0]) return 1'b0;
    return m_ctrl[1] ? m_flag : (m_left > 0);
  endfunction
  always @(posedge clk) begin
    logic ev;
    if (!rst_n) begin m_ctrl = 0; m_flag = 0; m_half = 0; m_left = 0; end
    else begin
      ev = model_event(m_ctrl[3:2], m_half);
      if (ev) m_flag = 1;
      else if (we && wa && !wd[2]) m_flag = 0;
      if (ev) m_left = PT;
      else if (tf && m_left > 0) m_left = m_left - 1;
      if (tf) m_half = !m_half;
      if (we && !wa) m_ctrl = wd;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(); tf = 0; cs = 0; cm = 0; ch = 0; we = 0; wa = 0; wd = 0; endtask
  task automatic cyc(); @(posedge clk); @(negedge clk); idle(); endtask
  task automatic wr(input logic a, input logic [3:0] d); we = 1; wa = a; wd = d; cyc(); endtask
  task automatic do_reset(); rst_n = 0; idle(); cyc(); cyc(); rst_n = 1; endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); do_reset();
    chk("R1 pin", pin, 0); chk("R1 flag", flag_rd, 0); chk("R1 ctrl", ctrl_rd, 0);

    wr(0, 4'b0110); chk("R9 ctrl readback", ctrl_rd, 6);
    cm = 1; tf = 1; ch = 1; cyc(); chk("R2 unselected taps", flag_rd, 0);
    cs = 1; cyc(); chk("R3 flag set", flag_rd, 1); chk("R7 pin low", pin, 1);
    cyc(); chk("R3 flag holds", flag_rd, 1);
    wr(1, 4'b0100); chk("R4 write one ignored", flag_rd, 1);
    wr(1, 4'b0000); chk("R4 cleared", flag_rd, 0); chk("R7 released same edge", pin, 0);
    cs = 1; we = 1; wa = 1; wd = 0; cyc(); chk("R5 event beats clear", flag_rd, 1);
    wr(0, 4'b0111); chk("R8 masked pin", pin, 0); chk("R8 flag kept", flag_rd, 1);
    wr(1, 0); cs = 1; cyc(); chk("R8 flag still records", flag_rd, 1); chk("R8 pin quiet", pin, 0);

    do_reset();
    tf = 1; cyc(); chk("R2 first fast strobe no event", flag_rd, 0);
    tf = 1; cyc(); chk("R2 second strobe event", flag_rd, 1); chk("R6 pulse start", pin, 1);
    cyc(); chk("R6 pulse holds", pin, 1);
    tf = 1; cyc(); chk("R6 one strobe in", pin, 1);
    tf = 1; cyc(); chk("R10 restart on strobe", pin, 1);
    tf = 1; cyc(); chk("R10 countdown after restart", pin, 1);
    wr(0, 4'b0100); wr(1, 0);
    tf = 1; cyc(); chk("R6 pulse ends after PT strobes", pin, 0);
    cs = 1; cyc(); chk("R6 sec pulse start", pin, 1);
    tf = 1; cyc(); chk("R6 sec pulse mid", pin, 1);
    tf = 1; cyc(); chk("R6 sec pulse end", pin, 0);
    chk("R3 flag in standard mode", flag_rd, 1);

    for (int i = 0; i < 4000; i++) begin
      chk(m_ctrl[1] ? "R7 random pin" : "R6 random pin", pin, model_pin());
      chk("R3 random flag", flag_rd, m_flag);
      chk("R9 random ctrl", ctrl_rd, m_ctrl);
      tf = ($urandom % 4) == 0; cs = ($urandom % 24) == 0;
      cm = ($urandom % 24) == 0; ch = ($urandom % 24) == 0;
      we = ($urandom % 6) == 0; wa = $urandom % 2; wd = 4'($urandom);
      rst_n = ($urandom % 1500) != 0;
      @(posedge clk); @(negedge clk);
      if (!rst_n) begin rst_n = 1; idle(); chk("R1 random reset", pin, 0); end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule